// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog for a processor subsystem. Software programs a reload value, loads it into a 32-bit down-counter by writing one fixed key to a restart register, and then enables counting. The counter steps down once per count tick. The tick comes either from a parameterised divider of the bus clock (nominally 1 MHz) or directly from the bus clock. If software does not repeat the keyed restart in time and the counter reaches zero, the block emits one-cycle expiry pulses: a reset request that carries the selected reset scope, an interrupt, and an external-signal trigger. Each of these is enabled separately.

A 32-bit word-addressed register bus gives access to the registers. The bus has an address, write data, a write strobe and registered read data. On expiry the block sets a sticky expiry flag. If the control register asked for the alternate boot image at that moment, it also sets a sticky alternate-boot flag, and that flag is brought out on a pin for the boot logic. Only the block reset clears the sticky flags.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, every register reads zero and the outputs rst_req, irq_pulse, ext_pulse, boot_alt and rst_scope are all low.
- R2: A write of exactly 0x00004755 to offset 0x08 copies the reload value into the counter. Any other value written there, including one that carries the key in bits 15:0 but has nonzero upper bits, leaves the counter unchanged.
- R3: Offset 0x04 holds the reload value and reads it back. Writing it does not change the count until the next keyed restart.
- R4: Control bit 0 enables counting. While it is clear, the counter holds its value.
- R5: Control bit 4 selects the tick source. When it is 1, the counter decrements once every TICK_DIV clocks. When it is 0, it decrements every clock. With bit 4 at 0 and a count of N, rst_req is high exactly N clocks after the enabling control write takes effect.
- R6: Expiry happens when a tick finds the counter at 1 and the counter goes to 0. On expiry, rst_req pulses if control bit 1 is set, irq_pulse pulses if control bit 2 is set, and ext_pulse pulses if control bit 3 is set. Each pulse lasts exactly one clock. The counter then stays at 0 and fires no more pulses. A counter that is enabled while already at 0 never expires.
- R7: While rst_req is high, rst_scope carries control bits 6:5 (00 SoC, 01 full chip, 10 CPU only). At all other times rst_scope is 00.
- R8: At offset 0x10, bit 0 is set on every expiry, and bit 1 is set on an expiry that occurs while control bit 7 is 1. Both bits are sticky until reset, and boot_alt follows bit 1.
- R9: Reads return data one clock after the address is presented. Offset 0x00 returns the current count. Offset 0x08 and unmapped offsets return zero.
- R10: Offset 0x0C stores bits 7:0 of a write and reads back with bits 31:8 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_scope | output | 2 | Reset scope, valid while rst_req is high |
| irq_pulse | output | 1 | One-cycle interrupt on expiry |
| ext_pulse | output | 1 | One-cycle external-signal trigger on expiry |
| boot_alt | output | 1 | Sticky alternate-boot flag |

## Verification
The assertions rely on a few properties of the inputs. The bus performs at most one write per clock. A keyed restart is an ordinary write whose effect shows on the next clock. Reset is synchronous and lasts at least one clock. The directed stimulus holds to all of this. Every write lasts exactly one clock, with the strobe dropped between writes. The counter is read back only while counting is disabled, so each value read is exact. Waits that depend on the divider phase are checked against a window of one divider period, not against a single cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned REG_W = 32;

  localparam logic [4:0] OFF_COUNT   = 5'h00;
  localparam logic [4:0] OFF_RELOAD  = 5'h04;
  localparam logic [4:0] OFF_KICK    = 5'h08;
  localparam logic [4:0] OFF_CTL     = 5'h0C;
  localparam logic [4:0] OFF_TSTAT   = 5'h10;

  localparam logic [REG_W-1:0] KICK_KEY = 32'h0000_4755;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'b00,
    SCOPE_CHIP = 2'b01,
    SCOPE_CPU  = 2'b10,
    SCOPE_RSVD = 2'b11
  } scope_e;

  // bit positions fixed: software composes the control word
  typedef struct packed {
    logic   alt_boot;  // 7
    scope_e scope;     // 6:5
    logic   src_fixed; // 4
    logic   ext_en;    // 3
    logic   irq_en;    // 2
    logic   rst_en;    // 1
    logic   run;       // 0
  } ctl_t;

  typedef struct packed {
    logic alt_seen;    // 1
    logic expired;     // 0
  } tstat_t;

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] phase;

  generate
    if (DIV <= 1) begin : g_bypass
      always_ff @(posedge clk) begin
        if (rst) begin
          phase <= '0;
          tick  <= 1'b0;
        end else begin
          phase <= '0;
          tick  <= 1'b1;
        end
      end
    end else begin : g_div
      always_ff @(posedge clk) begin
        if (rst) begin
          phase <= '0;
          tick  <= 1'b0;
        end else begin
          if (phase == LAST) phase <= '0;
          else               phase <= phase + 1'b1;
          tick <= (phase == LAST);
        end
      end

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("tick not isolated"); // R5
    end
  endgenerate

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic live;
  assign live = run && step && (count != '0);
  assign hit  = live && !load && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= reload_val;
    else if (live) count <= count - ONE;
  end

  AST_KEY_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(reload_val)) else $error("keyed load"); // R2

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count)) else $error("count moved while off"); // R4

  AST_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !load |=> count <= $past(count)) else $error("count rose without key"); // R3

  AST_HIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    hit |=> count == '0) else $error("expiry left count nonzero"); // R6

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req,
  output logic [1:0]        rst_scope,
  output logic              irq_pulse,
  output logic              ext_pulse,
  output logic              boot_alt
);

  localparam int unsigned CTL_W = $bits(ctl_t);
  localparam int unsigned TS_W  = $bits(tstat_t);

  ctl_t             ctl_q;
  tstat_t           ts_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             tick_fixed;
  logic             step;
  logic             hit;
  logic             kick;

  logic sel_reload, sel_kick, sel_ctl;
  assign sel_reload = bus_we && (bus_addr == ADDR_W'(OFF_RELOAD));
  assign sel_kick   = bus_we && (bus_addr == ADDR_W'(OFF_KICK));
  assign sel_ctl    = bus_we && (bus_addr == ADDR_W'(OFF_CTL));
  assign kick       = sel_kick && (bus_wdata == KICK_KEY);

  wdog_tick #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_fixed)
  );

  assign step = ctl_q.src_fixed ? tick_fixed : 1'b1;

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .run        (ctl_q.run),
    .load       (kick),
    .reload_val (reload_q),
    .count      (count),
    .hit        (hit)
  );

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      reload_q <= '0;
    end else begin
      if (sel_ctl)    ctl_q    <= ctl_t'(bus_wdata[CTL_W-1:0]);
      if (sel_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  // sticky timeout status
  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q <= '0;
    end else if (hit) begin
      ts_q.expired <= 1'b1;
      if (ctl_q.alt_boot) ts_q.alt_seen <= 1'b1;
    end
  end

  // registered expiry outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req   <= 1'b0;
      irq_pulse <= 1'b0;
      ext_pulse <= 1'b0;
      rst_scope <= 2'b00;
    end else begin
      rst_req   <= hit && ctl_q.rst_en;
      irq_pulse <= hit && ctl_q.irq_en;
      ext_pulse <= hit && ctl_q.ext_en;
      rst_scope <= (hit && ctl_q.rst_en) ? ctl_q.scope : 2'b00;
    end
  end

  assign boot_alt = ts_q.alt_seen;

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_W'(OFF_COUNT):  bus_rdata <= 32'(count);
        ADDR_W'(OFF_RELOAD): bus_rdata <= 32'(reload_q);
        ADDR_W'(OFF_CTL):    bus_rdata <= {{(32-CTL_W){1'b0}}, ctl_q};
        ADDR_W'(OFF_TSTAT):  bus_rdata <= {{(32-TS_W){1'b0}}, ts_q};
        default:             bus_rdata <= '0;
      endcase
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req) else $error("reset request too long"); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse) else $error("irq too long"); // R6

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(ctl_q.rst_en)) else $error("request while disabled"); // R6

  AST_SCOPE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rst_req |-> rst_scope == 2'b00) else $error("scope outside request"); // R7

  AST_EXP_STICKY: assert property (@(posedge clk) disable iff (rst)
    ts_q.expired |=> ts_q.expired) else $error("expiry flag dropped"); // R8

  AST_ALT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (hit && ctl_q.alt_boot) |=> boot_alt) else $error("alt boot not latched"); // R8

endmodule

// File: tb/wdog_keyed_bench.sv
module wdog_keyed_bench;

  localparam int unsigned DIV = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic        rst_req;
  logic [1:0]  rst_scope;
  logic        irq_pulse;
  logic        ext_pulse;
  logic        boot_alt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  wdog_keyed #(.TICK_DIV(DIV)) u_wdog_keyed (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req(rst_req),
    .rst_scope(rst_scope), .irq_pulse(irq_pulse), .ext_pulse(ext_pulse),
    .boot_alt(boot_alt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // cycles until rst_req or irq or ext shows, 0 if none within lim
  task automatic wait_fire(int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (rst_req || irq_pulse || ext_pulse) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h00, d); check("R1 count", d, 0);
    rd(5'h04, d); check("R1 reload", d, 0);
    rd(5'h0C, d); check("R1 ctl", d, 0);
    rd(5'h10, d); check("R1 tstat", d, 0);
    check("R1 outputs", {27'd0, rst_req, irq_pulse, ext_pulse, boot_alt, |rst_scope}, 0);
  endtask

  task automatic t_zero_enabled();
    int n;
    wr(5'h0C, 32'h0000_000F);
    wait_fire(20, n);
    check("R6 no expiry from zero", n, 0);
    wr(5'h0C, 32'h0);
  endtask

  task automatic t_fast_expiry();
    logic [31:0] d;
    int n;
    wr(5'h04, 32'd10);
    rd(5'h04, d); check("R3 reload readback", d, 10);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h0000_0027);  // run, rst_en, irq_en, scope 01, fast source
    wait_fire(40, n);
    check("R5 fast latency", n, 10);
    check("R6 rst_req", rst_req, 1);
    check("R6 irq", irq_pulse, 1);
    check("R6 ext gated off", ext_pulse, 0);
    check("R7 scope chip", rst_scope, 1);
    @(negedge clk);
    check("R6 single cycle", {rst_req, irq_pulse}, 0);
    check("R7 scope idle", rst_scope, 0);
    wait_fire(20, n);
    check("R6 no repeat", n, 0);
    rd(5'h00, d); check("R9 count at zero", d, 0);
    rd(5'h10, d); check("R8 expired only", d, 1);
    rd(5'h08, d); check("R9 kick reads zero", d, 0);
    rd(5'h14, d); check("R9 unmapped zero", d, 0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(5'h0C, 32'h0);
    wr(5'h08, 32'h0000_4756);
    rd(5'h00, d); check("R2 wrong key ignored", d, 0);
    wr(5'h08, 32'h0001_4755);
    rd(5'h00, d); check("R2 upper bits ignored", d, 0);
    wr(5'h08, 32'h0000_4755);
    rd(5'h00, d); check("R2 key loads", d, 10);
  endtask

  task automatic t_freeze();
    logic [31:0] d;
    repeat (30) @(negedge clk);
    rd(5'h00, d); check("R4 frozen", d, 10);
    wr(5'h04, 32'd99);
    rd(5'h00, d); check("R3 count unchanged", d, 10);
    wr(5'h08, 32'h0000_4755);
    rd(5'h00, d); check("R3 new reload after key", d, 99);
  endtask

  task automatic t_prescaled();
    logic [31:0] d;
    int n;
    wr(5'h04, 32'd3);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h0000_00DB);  // alt, scope 10, fixed src, ext, rst_en, run
    wait_fire(60, n);
    checks++;
    if (n < 2*DIV+1 || n > 3*DIV) begin
      fails++;
      $display("FAIL R5 prescaled latency: actual %0d expected %0d..%0d", n, 2*DIV+1, 3*DIV);
    end
    check("R6 ext", ext_pulse, 1);
    check("R6 irq gated off", irq_pulse, 0);
    check("R7 scope cpu", rst_scope, 2);
    @(negedge clk);
    check("R6 ext single", ext_pulse, 0);
    rd(5'h10, d); check("R8 both flags", d, 3);
    check("R8 boot_alt", boot_alt, 1);
  endtask

  task automatic t_ctl_bits();
    logic [31:0] d;
    wr(5'h0C, 32'hFFFF_FF5A);
    rd(5'h0C, d); check("R10 ctl width", d, 32'h5A);
  endtask

  task automatic t_gated_expiry();
    logic [31:0] d;
    int n;
    do_reset();
    wr(5'h04, 32'd2);
    wr(5'h08, 32'h0000_4755);
    wr(5'h0C, 32'h0000_0001);
    wait_fire(12, n);
    check("R6 silent expiry", n, 0);
    rd(5'h10, d); check("R8 silent expiry flag", d, 1);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    wr(5'h08, 32'h0000_4755);
    rd(5'h10, d); check("R8 sticky after key", d, 3);
    do_reset();
    rd(5'h10, d); check("R8 cleared by reset", d, 0);
    check("R1 boot_alt low", boot_alt, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    do_reset();
    t_reset();
    t_zero_enabled();
    t_fast_expiry();
    t_keys();
    t_freeze();
    t_prescaled();
    t_ctl_bits();
    t_sticky();
    t_gated_expiry();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule